// File: doc/BRIEF.md
# Packet Frame Encoder With Coding

This block turns one transmit packet into a serial bit stream. A frame has four parts in fixed order: a run of alternating preamble bytes, an identifier of two to eight bytes, a payload taken byte by byte from a request/valid interface, and an optional 16-bit checksum. Independently enabled coding stages act on the payload: scrambling by a 7-bit pseudo-random sequence, a (7,4) Hamming forward error correction code, and Manchester line coding.

All configuration comes in on static inputs. A one-cycle start pulse captures it and launches the frame. Each transmitted bit is marked by an enable strobe, and a single-cycle done pulse follows the last bit. The stream may pause between units (bytes, codewords, checksum), so a consumer takes bits only when the strobe is high.

Top module: `frame_coder`

## Requirements
- R1: After reset, `tx_bit_en`, `frame_done` and `pay_req` are low and stay low until a start pulse arrives.
- R2: The preamble length is picked by `pre_len_sel`: codes 0 to 7 give 1, 2, 3, 4, 16, 32, 48 and 64 bytes. Each preamble byte is 0xAA when bit 63 of `id_word` is 1 and 0x55 when it is 0.
- R3: The identifier length is picked by `id_len_sel`: codes 0 to 3 give 2, 4, 6 and 8 bytes, taken from `id_word` starting at bits [63:56] and moving downward. Every byte of every part is sent most significant bit first.
- R4: A payload byte is taken in each cycle where `pay_req` and `pay_valid` are both high. Exactly `pay_len` bytes are taken. A length of zero sends no payload and never raises `pay_req`.
- R5: With `whiten_en` set, each payload bit is XORed with bit 6 of a 7-bit register loaded from `white_seed` at each start. After each bit the register shifts left by one and takes bit6 XOR bit3 into bit 0 (polynomial x^7 + x^4 + 1).
- R6: With `fec_en` set, each payload byte is split into its high nibble and then its low nibble. A nibble d3..d0 is sent as the seven bits d3 d2 d1 d0 p2 p1 p0, where p2 = d3^d2^d1, p1 = d3^d2^d0 and p0 = d3^d1^d0.
- R7: With `manch_en` set, each coded payload bit is sent as two bits: a 1 as 1 then 0, and a 0 as 0 then 1. Preamble, identifier and checksum bits are never Manchester coded.
- R8: With `crc_en` set, a 16-bit checksum follows the payload, uncoded and most significant bit first. It uses polynomial 0x1021 and start value 0xFFFF over the payload bytes as they were received, before scrambling. With `crc_en` clear, nothing follows the payload.
- R9: With `crc_inv` set, the bitwise complement of the checksum is sent instead.
- R10: `frame_done` is high for exactly one cycle, the cycle after the last bit of the frame. A start pulse during a frame is ignored, and so is any change of the configuration inputs during a frame.
- R11: When several stages are enabled, scrambling comes first, the Hamming code second and Manchester coding last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a frame when idle |
| pre_len_sel | input | 3 | Preamble length code |
| id_len_sel | input | 2 | Identifier length code |
| whiten_en | input | 1 | Payload scrambling enable |
| fec_en | input | 1 | Hamming (7,4) enable |
| manch_en | input | 1 | Manchester coding enable |
| crc_en | input | 1 | Checksum append enable |
| crc_inv | input | 1 | Send the complemented checksum |
| white_seed | input | 7 | Scrambler start state |
| id_word | input | 64 | Identifier bytes, first byte in [63:56] |
| pay_len | input | LEN_W | Payload byte count |
| pay_req | output | 1 | Block is ready to take a payload byte |
| pay_valid | input | 1 | Payload byte offered on pay_data |
| pay_data | input | 8 | Payload byte |
| tx_bit | output | 1 | Serial output bit |
| tx_bit_en | output | 1 | tx_bit carries a frame bit this cycle |
| frame_done | output | 1 | Pulse after the last frame bit |

## Verification
The assertions assume that `pay_valid` and `pay_data` hold steady only through the cycle in which they are sampled, and that the source reacts to `pay_req` alone. The bench's payload source honours this: it changes `pay_valid` at random on falling edges and moves to the next byte only after an accepted transfer. The in-module checks also assume a nonzero scrambler seed whenever scrambling matters. The random frames therefore draw seeds from 1 to 127, and a directed frame covers the zero seed, where scrambling has no effect. Frames with a start pulse mid-flight also change every configuration input at that moment, so the latching rule is exercised at the ports.

// File: rtl/frame_coder_pkg.sv
package frame_coder_pkg;

    localparam int ID_BITS   = 64;
    localparam int SER_W     = 16;
    localparam int SER_CNT_W = 5;

    typedef struct packed {
        logic [2:0] pre_sel;
        logic [1:0] id_sel;
        logic       whiten;
        logic       fec;
        logic       manch;
        logic       crc;
        logic       crc_inv;
        logic [6:0] seed;
    } coder_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ID,
        ST_PAY,
        ST_CRC,
        ST_FIN
    } coder_state_t;

    // Preamble byte count from its 3-bit code.
    function automatic logic [6:0] pre_bytes(input logic [2:0] code);
        logic [6:0] n;
        if (code[2] == 1'b0) n = 7'(code) + 7'd1;
        else                 n = {1'b0, 7'(code[1:0]) + 7'd1} << 4;
        return n;
    endfunction

    // Identifier byte count from its 2-bit code.
    function automatic logic [3:0] id_bytes(input logic [1:0] code);
        return {1'b0, code, 1'b0} + 4'd2;
    endfunction

    // One nibble into a 7-bit codeword, data bits leading.
    function automatic logic [6:0] ham74(input logic [3:0] d);
        logic p2, p1, p0;
        p2 = d[3] ^ d[2] ^ d[1];
        p1 = d[3] ^ d[2] ^ d[0];
        p0 = d[3] ^ d[1] ^ d[0];
        return {d, p2, p1, p0};
    endfunction

    // Checksum advanced over one byte, MSB first.
    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) begin
            if (r[15]) r = (r << 1) ^ 16'h1021;
            else       r = r << 1;
        end
        return r;
    endfunction

    // Eight scrambler output bits, first bit in position 7.
    function automatic logic [7:0] pn_mask(input logic [6:0] s_in);
        logic [6:0] s;
        logic [7:0] m;
        s = s_in;
        m = '0;
        for (int i = 0; i < 8; i++) begin
            m[7-i] = s[6];
            s = {s[5:0], s[6] ^ s[3]};
        end
        return m;
    endfunction

    function automatic logic [6:0] pn_step8(input logic [6:0] s_in);
        logic [6:0] s;
        s = s_in;
        for (int i = 0; i < 8; i++) s = {s[5:0], s[6] ^ s[3]};
        return s;
    endfunction

endpackage

// File: rtl/frame_coder_pn7.sv
module frame_coder_pn7
    import frame_coder_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [6:0] seed,
    input  logic       adv,
    output logic [7:0] mask
);
    logic [6:0] state;

    always_ff @(posedge clk) begin
        if (rst)       state <= '0;
        else if (load) state <= seed;
        else if (adv)  state <= pn_step8(state);
    end

    assign mask = pn_mask(state);

    // A nonzero scrambler state never collapses to zero (R5)
    assert_pn_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
        (state != 7'd0 && !load) |=> (state != 7'd0));

endmodule

// File: rtl/frame_coder_crc.sv
module frame_coder_crc
    import frame_coder_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  data,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) crc <= 16'hFFFF;
        else if (upd)   crc <= crc_byte(crc, data);
    end

    // A new frame always starts its checksum from the fixed start value (R8)
    assert_crc_start_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc == 16'hFFFF));

endmodule

// File: rtl/frame_coder_ser.sv
module frame_coder_ser
    import frame_coder_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [SER_W-1:0]     word,
    input  logic [SER_CNT_W-1:0] nbits,
    input  logic                 manch,
    output logic                 ready,
    output logic                 bit_o,
    output logic                 bit_en
);
    logic [SER_W-1:0]     sh;
    logic [SER_CNT_W-1:0] left;
    logic                 half;
    logic                 manch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            left    <= '0;
            half    <= 1'b0;
            manch_q <= 1'b0;
        end else if (load) begin
            sh      <= word;
            left    <= nbits;
            half    <= 1'b0;
            manch_q <= manch;
        end else if (left != '0) begin
            if (manch_q && !half) begin
                half <= 1'b1;
            end else begin
                half <= 1'b0;
                sh   <= sh << 1;
                left <= left - 1'b1;
            end
        end
    end

    assign ready  = (left == '0);
    assign bit_en = !ready;
    assign bit_o  = (manch_q && half) ? ~sh[SER_W-1] : sh[SER_W-1];

    // A unit is only loaded once the previous one has fully left (R10)
    assert_load_empty_R10: assert property (@(posedge clk) disable iff (rst)
        load |-> ready);

    // Second half of a Manchester pair is the complement of the first (R7)
    assert_manch_pair_R7: assert property (@(posedge clk) disable iff (rst)
        (bit_en && manch_q && half) |-> (bit_o != $past(bit_o)));

endmodule

// File: rtl/frame_coder.sv
module frame_coder
    import frame_coder_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        pre_len_sel,
    input  logic [1:0]        id_len_sel,
    input  logic              whiten_en,
    input  logic              fec_en,
    input  logic              manch_en,
    input  logic              crc_en,
    input  logic              crc_inv,
    input  logic [6:0]        white_seed,
    input  logic [63:0]       id_word,
    input  logic [LEN_W-1:0]  pay_len,
    output logic              pay_req,
    input  logic              pay_valid,
    input  logic [7:0]        pay_data,
    output logic              tx_bit,
    output logic              tx_bit_en,
    output logic              frame_done
);
    localparam int CNT_W = (LEN_W > 7) ? LEN_W : 7;

    coder_cfg_t        cfg_q;
    logic [ID_BITS-1:0] id_q;
    logic [LEN_W-1:0]  len_q;
    coder_state_t      st, st_d;
    logic [CNT_W-1:0]  cnt, cnt_d;

    logic                 launch;
    logic                 ser_ready, ser_load, ser_manch;
    logic [SER_W-1:0]     ser_word;
    logic [SER_CNT_W-1:0] ser_nbits;
    logic                 pay_fire;
    logic [7:0]           pn_bits;
    logic [15:0]          crc_val;
    logic [7:0]           pre_byte, id_byte, white_byte;
    logic [ID_BITS-1:0]   id_sh;
    logic [SER_W-1:0]     pay_word;
    logic                 last_pre, last_id, last_pay;
    coder_state_t         tail_st;

    assign launch   = (st == ST_IDLE) && start;
    assign pay_req  = (st == ST_PAY) && ser_ready;
    assign pay_fire = pay_req && pay_valid;

    assign pre_byte   = id_q[ID_BITS-1] ? 8'hAA : 8'h55;
    assign id_sh      = id_q << {cnt[2:0], 3'b000};
    assign id_byte    = id_sh[ID_BITS-1 -: 8];
    assign white_byte = cfg_q.whiten ? (pay_data ^ pn_bits) : pay_data;
    assign pay_word   = cfg_q.fec ? {ham74(white_byte[7:4]), ham74(white_byte[3:0]), 2'b00}
                                  : {white_byte, 8'h00};

    assign last_pre = (cnt == CNT_W'(pre_bytes(cfg_q.pre_sel)) - CNT_W'(1));
    assign last_id  = (cnt == CNT_W'(id_bytes(cfg_q.id_sel)) - CNT_W'(1));
    assign last_pay = (cnt == CNT_W'(len_q) - CNT_W'(1));
    assign tail_st  = cfg_q.crc ? ST_CRC : ST_FIN;

    always_comb begin
        st_d       = st;
        cnt_d      = cnt;
        ser_load   = 1'b0;
        ser_word   = '0;
        ser_nbits  = '0;
        ser_manch  = 1'b0;
        frame_done = 1'b0;
        case (st)
            ST_IDLE: begin
                if (start) begin
                    st_d  = ST_PRE;
                    cnt_d = '0;
                end
            end
            ST_PRE: begin
                if (ser_ready) begin
                    ser_load  = 1'b1;
                    ser_word  = {pre_byte, 8'h00};
                    ser_nbits = SER_CNT_W'(8);
                    if (last_pre) begin
                        st_d  = ST_ID;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt + 1'b1;
                    end
                end
            end
            ST_ID: begin
                if (ser_ready) begin
                    ser_load  = 1'b1;
                    ser_word  = {id_byte, 8'h00};
                    ser_nbits = SER_CNT_W'(8);
                    if (last_id) begin
                        st_d  = (len_q != '0) ? ST_PAY : tail_st;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt + 1'b1;
                    end
                end
            end
            ST_PAY: begin
                if (pay_fire) begin
                    ser_load  = 1'b1;
                    ser_word  = pay_word;
                    ser_nbits = cfg_q.fec ? SER_CNT_W'(14) : SER_CNT_W'(8);
                    ser_manch = cfg_q.manch;
                    if (last_pay) begin
                        st_d  = tail_st;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt + 1'b1;
                    end
                end
            end
            ST_CRC: begin
                if (ser_ready) begin
                    ser_load  = 1'b1;
                    ser_word  = crc_val ^ {16{cfg_q.crc_inv}};
                    ser_nbits = SER_CNT_W'(16);
                    st_d      = ST_FIN;
                end
            end
            ST_FIN: begin
                if (ser_ready) begin
                    frame_done = 1'b1;
                    st_d       = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            cfg_q <= '0;
            id_q  <= '0;
            len_q <= '0;
        end else begin
            st  <= st_d;
            cnt <= cnt_d;
            if (launch) begin
                cfg_q <= '{pre_sel: pre_len_sel, id_sel: id_len_sel, whiten: whiten_en,
                           fec: fec_en, manch: manch_en, crc: crc_en, crc_inv: crc_inv,
                           seed: white_seed};
                id_q  <= id_word;
                len_q <= pay_len;
            end
        end
    end

    frame_coder_pn7 pn_i (
        .clk  (clk),
        .rst  (rst),
        .load (launch),
        .seed (white_seed),
        .adv  (pay_fire),
        .mask (pn_bits)
    );

    frame_coder_crc crc_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (launch),
        .upd  (pay_fire),
        .data (pay_data),
        .crc  (crc_val)
    );

    frame_coder_ser ser_i (
        .clk    (clk),
        .rst    (rst),
        .load   (ser_load),
        .word   (ser_word),
        .nbits  (ser_nbits),
        .manch  (ser_manch),
        .ready  (ser_ready),
        .bit_o  (tx_bit),
        .bit_en (tx_bit_en)
    );

    // Payload is only requested while the output stream is paused (R4)
    assert_req_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        pay_req |-> !tx_bit_en);

    // No more bytes are requested than the latched length (R4)
    assert_pay_bound_R4: assert property (@(posedge clk) disable iff (rst)
        pay_req |-> (CNT_W'(len_q) > cnt));

    // Done is a lone pulse and no bit follows it directly (R10)
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (!frame_done && !tx_bit_en));

    // Nothing leaves the block while idle (R1)
    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && $past(st) == ST_IDLE && !$past(frame_done)) |-> !tx_bit_en);

endmodule

// File: tb/frame_coder_tb.sv
module frame_coder_tb_top;

    localparam int LEN_W = 8;
    localparam int WD_LIMIT = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [2:0]       pre_len_sel = '0;
    logic [1:0]       id_len_sel = '0;
    logic             whiten_en = 1'b0;
    logic             fec_en = 1'b0;
    logic             manch_en = 1'b0;
    logic             crc_en = 1'b0;
    logic             crc_inv = 1'b0;
    logic [6:0]       white_seed = '0;
    logic [63:0]      id_word = '0;
    logic [LEN_W-1:0] pay_len = '0;
    logic             pay_req;
    logic             pay_valid = 1'b0;
    logic [7:0]       pay_data;
    logic             tx_bit, tx_bit_en, frame_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int idx = 0;
    bit idx_clr = 1'b0;
    bit valid_rand = 1'b0;
    int done_cnt = 0;
    logic [7:0] pay_mem [0:255];
    bit got_q[$];
    bit exp_q[$];

    always #10 clk = ~clk;

    frame_coder #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .pre_len_sel(pre_len_sel), .id_len_sel(id_len_sel),
        .whiten_en(whiten_en), .fec_en(fec_en), .manch_en(manch_en),
        .crc_en(crc_en), .crc_inv(crc_inv), .white_seed(white_seed),
        .id_word(id_word), .pay_len(pay_len),
        .pay_req(pay_req), .pay_valid(pay_valid), .pay_data(pay_data),
        .tx_bit(tx_bit), .tx_bit_en(tx_bit_en), .frame_done(frame_done)
    );

    assign pay_data = pay_mem[idx[7:0]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (idx_clr) idx <= 0;
        else if (pay_req && pay_valid) idx <= idx + 1;
    end

    always @(negedge clk) begin
        if (tx_bit_en) got_q.push_back(tx_bit);
        if (frame_done) done_cnt = done_cnt + 1;
        pay_valid = valid_rand ? (($urandom % 4) != 0) : 1'b1;
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        wait (cyc >= WD_LIMIT);
        errors = errors + 1;
        $display("FAIL watchdog R10: actual no completion expected done within %0d cycles", WD_LIMIT);
        finish_run();
    end

    task automatic check(input bit ok, input string what, input string act, input string exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %s expected %s", what, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
    endtask

    task automatic push_pay_bit(input bit b, input bit man);
        exp_q.push_back(b);
        if (man) exp_q.push_back(!b);
    endtask

    // Expected frame built from the requirement text
    task automatic build_expect(input logic [2:0] ps, input logic [1:0] is, input bit wh,
                                input bit fe, input bit mn, input bit ce, input bit ci,
                                input logic [6:0] sd, input logic [63:0] idw, input int len);
        int npre;
        int nid;
        logic [6:0] s;
        logic [15:0] c;
        logic [7:0] w;
        exp_q.delete();
        case (ps)
            3'd0: npre = 1;  3'd1: npre = 2;  3'd2: npre = 3;  3'd3: npre = 4;
            3'd4: npre = 16; 3'd5: npre = 32; 3'd6: npre = 48; default: npre = 64;
        endcase
        nid = 2 * (int'(is) + 1);
        for (int i = 0; i < npre; i++) push_byte(idw[63] ? 8'hAA : 8'h55);
        for (int i = 0; i < nid; i++) push_byte(idw[63 - 8*i -: 8]);
        s = sd;
        c = 16'hFFFF;
        for (int k = 0; k < len; k++) begin
            logic [7:0] b;
            b = pay_mem[k];
            c = c ^ {b, 8'h00};
            for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
            for (int j = 7; j >= 0; j--) begin
                w[j] = wh ? (b[j] ^ s[6]) : b[j];
                s = {s[5:0], s[6] ^ s[3]};
            end
            if (fe) begin
                for (int h = 1; h >= 0; h--) begin
                    logic [3:0] d;
                    d = h ? w[7:4] : w[3:0];
                    for (int j = 3; j >= 0; j--) push_pay_bit(d[j], mn);
                    push_pay_bit(d[3] ^ d[2] ^ d[1], mn);
                    push_pay_bit(d[3] ^ d[2] ^ d[0], mn);
                    push_pay_bit(d[3] ^ d[1] ^ d[0], mn);
                end
            end else begin
                for (int j = 7; j >= 0; j--) push_pay_bit(w[j], mn);
            end
        end
        if (ce) begin
            if (ci) c = ~c;
            for (int j = 15; j >= 0; j--) exp_q.push_back(c[j]);
        end
    endtask

    task automatic run_frame(input string tag, input logic [2:0] ps, input logic [1:0] is,
                             input bit wh, input bit fe, input bit mn, input bit ce, input bit ci,
                             input logic [6:0] sd, input logic [63:0] idw, input int len,
                             input bit vr, input bit restart);
        int d0;
        int first_bad;
        build_expect(ps, is, wh, fe, mn, ce, ci, sd, idw, len);
        @(negedge clk);
        got_q.delete();
        idx_clr = 1'b1;
        valid_rand = vr;
        pre_len_sel = ps; id_len_sel = is; whiten_en = wh; fec_en = fe; manch_en = mn;
        crc_en = ce; crc_inv = ci; white_seed = sd; id_word = idw; pay_len = LEN_W'(len);
        d0 = done_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idx_clr = 1'b0;
        if (restart) begin
            repeat (20) @(negedge clk);
            pre_len_sel = ~ps; id_len_sel = ~is; whiten_en = !wh; fec_en = !fe;
            manch_en = !mn; crc_en = !ce; crc_inv = !ci; white_seed = ~sd;
            id_word = ~idw; pay_len = LEN_W'(len + 3);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(got_q.size() == exp_q.size(), $sformatf("%s bit count", tag),
              $sformatf("%0d", got_q.size()), $sformatf("%0d", exp_q.size()));
        first_bad = -1;
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (first_bad < 0 && got_q[i] != exp_q[i]) first_bad = i;
        check(first_bad < 0, $sformatf("%s bit content (first mismatch index %0d)", tag, first_bad),
              (first_bad < 0) ? "match" : $sformatf("%0b", got_q[first_bad]),
              (first_bad < 0) ? "match" : $sformatf("%0b", exp_q[first_bad]));
        check(idx == len, $sformatf("%s R4 bytes taken", tag),
              $sformatf("%0d", idx), $sformatf("%0d", len));
        check(done_cnt == d0 + 1, $sformatf("%s R10 done pulses", tag),
              $sformatf("%0d", done_cnt - d0), "1");
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 256; i++) pay_mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        check(!tx_bit_en && !frame_done && !pay_req, "R1 outputs in reset", 
              $sformatf("%0b%0b%0b", tx_bit_en, frame_done, pay_req), "000");
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(!tx_bit_en && !frame_done && !pay_req, "R1 outputs idle after reset",
              $sformatf("%0b%0b%0b", tx_bit_en, frame_done, pay_req), "000");

        // Plain frame: preamble 0x55 path, no coding
        run_frame("R2 R3 plain", 3'd0, 2'd0, 0, 0, 0, 0, 0, 7'h00, 64'h1234_5678_9ABC_DEF0, 3, 0, 0);
        // Longest preamble and identifier, 0xAA pattern, no payload
        run_frame("R2 R3 R4 longest header", 3'd7, 2'd3, 0, 0, 0, 0, 0, 7'h01, 64'hC3A5_0F1E_2D3C_4B5A, 0, 0, 0);
        // Empty payload with checksum: sends 0xFFFF
        run_frame("R8 empty crc", 3'd4, 2'd1, 0, 0, 0, 1, 0, 7'h11, 64'h8000_0000_0000_0001, 0, 0, 0);
        run_frame("R9 empty crc inverted", 3'd1, 2'd0, 0, 0, 0, 1, 1, 7'h11, 64'h8000_0000_0000_0001, 0, 0, 0);
        run_frame("R5 whitening", 3'd2, 2'd1, 1, 0, 0, 0, 0, 7'h7F, 64'hF0E1_D2C3_B4A5_9687, 9, 1, 0);
        run_frame("R5 zero seed", 3'd0, 2'd0, 1, 0, 0, 1, 0, 7'h00, 64'h0F0F_0F0F_0F0F_0F0F, 4, 0, 0);
        run_frame("R6 hamming", 3'd3, 2'd2, 0, 1, 0, 0, 0, 7'h2A, 64'h5555_AAAA_3333_CCCC, 6, 1, 0);
        run_frame("R7 manchester", 3'd1, 2'd0, 0, 0, 1, 1, 0, 7'h2A, 64'hFFFF_0000_FFFF_0000, 5, 0, 0);
        run_frame("R8 R11 all stages", 3'd5, 2'd3, 1, 1, 1, 1, 0, 7'h35, 64'h0123_4567_89AB_CDEF, 12, 1, 0);
        run_frame("R9 R11 all stages inverted", 3'd6, 2'd2, 1, 1, 1, 1, 1, 7'h4C, 64'hFEDC_BA98_7654_3210, 7, 1, 0);
        run_frame("R10 restart ignored", 3'd3, 2'd1, 1, 0, 1, 1, 0, 7'h19, 64'h9999_6666_1111_EEEE, 10, 1, 1);

        // Random frames across all option mixes
        for (int n = 0; n < 14; n++) begin
            logic [2:0] ps;
            ps = 3'($urandom % 8);
            run_frame($sformatf("R2 R3 R4 R5 R6 R7 R8 R9 R11 random %0d", n), ps, 2'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                      7'(($urandom % 127) + 1), {$urandom, $urandom},
                      int'($urandom % 24), 1'($urandom), (n % 4) == 3);
        end

        repeat (4) @(negedge clk);
        check(!tx_bit_en && !pay_req, "R1 idle after all frames",
              $sformatf("%0b%0b", tx_bit_en, pay_req), "00");
        finish_run();
    end

endmodule